// File: doc/BRIEF.md
# MI Snooping Coherence Controller

This block is the coherence engine of one node in a broadcast snooping system that knows only two stable block states, Modified and Idle. A third, transient state covers the time between this node broadcasting its exclusive request and the arrival of the data. The block watches three incoming queues, each shown to it as a head entry with a valid bit: the local processor's load/store queue, the broadcast address network and the point-to-point data network. It dequeues a head entry with a one-cycle pop strobe. It enqueues outgoing exclusive requests on the address network and data replies on the data network, each gated by a space flag from that output queue.

Every block address owns one state entry and one data word. There is no replacement. In each cycle the controller picks at most one event, looks up the block's state and commits one atomic transition. A transition that cannot finish leaves every queue and every state untouched. Data is held in a single-port, read-first synchronous RAM, so block data returned to the processor or to a remote requestor appears one cycle after the transition, together with the other registered outputs.

Top module: `mi_snoop_ctrl`

## Requirements
- R1: After synchronous reset every block is Idle, all registered outputs are low and the error flag is clear.
- R2: A processor request to an Idle block, with output space, enqueues next cycle an exclusive request (type code 2'b01) carrying the block address and this node's ID. The block becomes transient and the processor entry is not popped.
- R3: A processor request to a Modified block pops the entry. One cycle later a response pulse carries the block's data as it was before the request. A store (write bit 1) also replaces that data with the request's write data.
- R4: An exclusive request from another node that hits a Modified block, with reply space, pops the snoop. Next cycle it sends the block data to that requestor and the block becomes Idle.
- R5: An exclusive request from another node that hits an Idle block only pops the snoop.
- R6: In the transient state, both processor requests and exclusive requests from other nodes for that block stall: nothing is popped or sent and the state holds.
- R7: A data message for a transient block writes its data, pops the message and makes the block Modified.
- R8: A data message for an Idle or Modified block is popped without touching data or state, and it sets an error flag that stays set until reset.
- R9: If the output queue that a transition needs has no space, the transition stalls completely.
- R10: A snooped message whose requestor equals this node's ID, or whose type is not 2'b01, is popped with no other effect.
- R11: At most one input is popped per cycle, and the data network has priority over the address network, which has priority over the processor queue. A stalled head blocks the lower-priority inputs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_valid | input | 1 | Processor queue head valid |
| proc_write | input | 1 | Head is a store (1) or load (0) |
| proc_addr | input | ADDR_W | Block address of the processor request |
| proc_wdata | input | DATA_W | Store data |
| proc_pop | output | 1 | Dequeue processor head |
| proc_resp_valid | output | 1 | Hit response pulse |
| proc_resp_data | output | DATA_W | Block data before the request |
| snp_valid | input | 1 | Address network head valid |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_type | input | 2 | Request type (2'b01 exclusive) |
| snp_src | input | NODE_W | Requestor ID |
| snp_pop | output | 1 | Dequeue address network head |
| fill_valid | input | 1 | Data network head valid |
| fill_addr | input | ADDR_W | Data message block address |
| fill_data | input | DATA_W | Data message block |
| fill_pop | output | 1 | Dequeue data network head |
| getx_space | input | 1 | Outgoing address queue has room |
| getx_valid | output | 1 | Enqueue exclusive request |
| getx_addr | output | ADDR_W | Request block address |
| getx_type | output | 2 | Request type, always 2'b01 |
| getx_src | output | NODE_W | This node's ID |
| xfer_space | input | 1 | Outgoing data queue has room |
| xfer_valid | output | 1 | Enqueue data reply |
| xfer_addr | output | ADDR_W | Reply block address |
| xfer_dest | output | NODE_W | Reply destination node |
| xfer_data | output | DATA_W | Reply block data |
| err_flag | output | 1 | Sticky impossible-transition flag |

## Verification
The bench builds the controller with its defaults: 3 address bits (8 blocks), 32-bit data, 2-bit node IDs and this node as ID 1. That leaves room for three foreign requestor IDs and for this node's own echoed requests. With only eight blocks, a random phase that draws addresses from four of them makes the stall, priority and error cases collide often. A directed phase first drives every block through the transient state to fill and hit, and checks each space-starved stall on its own.

// File: rtl/mi_snoop_pkg.sv
package mi_snoop_pkg;

  typedef enum logic [1:0] {
    BLK_I  = 2'd0,
    BLK_M  = 2'd1,
    BLK_IM = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FILL = 2'd1,
    SRC_SNP  = 2'd2,
    SRC_PRC  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_LDST  = 3'd1,
    EV_OTHER = 3'd2,
    EV_DROP  = 3'd3,
    EV_FILL  = 3'd4
  } event_e;

  localparam logic [1:0] REQ_GETX = 2'b01;

  // actions of one committed transition
  typedef struct packed {
    logic       pop;
    logic       issue;
    logic       reply;
    logic       fill;
    logic       hit;
    logic       err;
    logic       upd;
    blk_state_e nxt;
  } xact_t;

endpackage

// File: rtl/mi_event_arb.sv
module mi_event_arb
  import mi_snoop_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input  logic              proc_valid,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_type,
  input  logic [NODE_W-1:0] snp_src,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output src_e              src,
  output event_e            ev,
  output logic [ADDR_W-1:0] ev_addr
);

  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  logic snp_foreign;
  assign snp_foreign = (snp_type == REQ_GETX) && (snp_src != MY_ID);

  // fixed priority: data network, address network, processor
  always_comb begin
    src     = SRC_NONE;
    ev      = EV_NONE;
    ev_addr = '0;
    if (fill_valid) begin
      src     = SRC_FILL;
      ev      = EV_FILL;
      ev_addr = fill_addr;
    end else if (snp_valid) begin
      src     = SRC_SNP;
      ev      = snp_foreign ? EV_OTHER : EV_DROP;
      ev_addr = snp_addr;
    end else if (proc_valid) begin
      src     = SRC_PRC;
      ev      = EV_LDST;
      ev_addr = proc_addr;
    end
  end

endmodule

// File: rtl/mi_xact_table.sv
module mi_xact_table
  import mi_snoop_pkg::*;
(
  input  event_e     ev,
  input  blk_state_e cur,
  input  logic       getx_space,
  input  logic       xfer_space,
  output xact_t      act
);

  always_comb begin
    act     = '0;
    act.nxt = cur;
    unique case (ev)
      EV_LDST: begin
        unique case (cur)
          BLK_I: if (getx_space) begin
            act.issue = 1'b1;
            act.upd   = 1'b1;
            act.nxt   = BLK_IM;
          end
          BLK_M: begin
            act.pop = 1'b1;
            act.hit = 1'b1;
          end
          default: ; // transient: stall
        endcase
      end
      EV_OTHER: begin
        unique case (cur)
          BLK_I: act.pop = 1'b1;
          BLK_M: if (xfer_space) begin
            act.pop   = 1'b1;
            act.reply = 1'b1;
            act.upd   = 1'b1;
            act.nxt   = BLK_I;
          end
          default: ; // transient: stall
        endcase
      end
      EV_DROP: act.pop = 1'b1;
      EV_FILL: begin
        act.pop = 1'b1;
        if (cur == BLK_IM) begin
          act.fill = 1'b1;
          act.upd  = 1'b1;
          act.nxt  = BLK_M;
        end else begin
          act.err = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mi_state_array.sv
module mi_state_array
  import mi_snoop_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  blk_state_e        wstate,
  output blk_state_e        rstate
);

  localparam int NBLK = 1 << ADDR_W;

  blk_state_e ent [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= BLK_I;
      else if (we && (addr == ADDR_W'(g)))
        ent[g] <= wstate;
    end
  end

  assign rstate = ent[addr];

endmodule

// File: rtl/mi_data_ram.sv
module mi_data_ram #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-first, registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    q <= mem[addr];
  end

endmodule

// File: rtl/mi_snoop_ctrl.sv
module mi_snoop_ctrl
  import mi_snoop_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_valid,
  input  logic              proc_write,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic [DATA_W-1:0] proc_wdata,
  output logic              proc_pop,
  output logic              proc_resp_valid,
  output logic [DATA_W-1:0] proc_resp_data,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_type,
  input  logic [NODE_W-1:0] snp_src,
  output logic              snp_pop,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              fill_pop,
  input  logic              getx_space,
  output logic              getx_valid,
  output logic [ADDR_W-1:0] getx_addr,
  output logic [1:0]        getx_type,
  output logic [NODE_W-1:0] getx_src,
  input  logic              xfer_space,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [NODE_W-1:0] xfer_dest,
  output logic [DATA_W-1:0] xfer_data,
  output logic              err_flag
);

  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  src_e              src;
  event_e            ev;
  logic [ADDR_W-1:0] ev_addr;
  blk_state_e        cur_state;
  xact_t             act;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wd;
  logic [DATA_W-1:0] ram_q;

  mi_event_arb #(
    .ADDR_W (ADDR_W),
    .NODE_W (NODE_W),
    .NODE_ID(NODE_ID)
  ) u_arb (
    .proc_valid(proc_valid),
    .proc_addr (proc_addr),
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr),
    .snp_type  (snp_type),
    .snp_src   (snp_src),
    .fill_valid(fill_valid),
    .fill_addr (fill_addr),
    .src       (src),
    .ev        (ev),
    .ev_addr   (ev_addr)
  );

  mi_state_array #(.ADDR_W(ADDR_W)) u_state (
    .clk   (clk),
    .rst   (rst),
    .addr  (ev_addr),
    .we    (act.upd),
    .wstate(act.nxt),
    .rstate(cur_state)
  );

  mi_xact_table u_table (
    .ev        (ev),
    .cur       (cur_state),
    .getx_space(getx_space),
    .xfer_space(xfer_space),
    .act       (act)
  );

  assign ram_we = act.fill || (act.hit && proc_write);
  assign ram_wd = act.fill ? fill_data : proc_wdata;

  mi_data_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk (clk),
    .addr(ev_addr),
    .we  (ram_we),
    .wd  (ram_wd),
    .q   (ram_q)
  );

  // dequeue strobes
  assign fill_pop = act.pop && (src == SRC_FILL);
  assign snp_pop  = act.pop && (src == SRC_SNP);
  assign proc_pop = act.pop && (src == SRC_PRC);

  // registered message outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      getx_valid      <= 1'b0;
      getx_addr       <= '0;
      xfer_valid      <= 1'b0;
      xfer_addr       <= '0;
      xfer_dest       <= '0;
      proc_resp_valid <= 1'b0;
      err_flag        <= 1'b0;
    end else begin
      getx_valid      <= act.issue;
      xfer_valid      <= act.reply;
      proc_resp_valid <= act.hit;
      err_flag        <= err_flag || act.err;
      if (act.issue) getx_addr <= ev_addr;
      if (act.reply) begin
        xfer_addr <= ev_addr;
        xfer_dest <= snp_src;
      end
    end
  end

  assign getx_type      = REQ_GETX;
  assign getx_src       = MY_ID;
  assign xfer_data      = ram_q;
  assign proc_resp_data = ram_q;

  // R11: one event per cycle, fixed priority
  p_one_pop_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({proc_pop, snp_pop, fill_pop}) <= 1);
  p_snp_prio_r11: assert property (@(posedge clk) disable iff (rst)
    snp_pop |-> !fill_valid);
  p_prc_prio_r11: assert property (@(posedge clk) disable iff (rst)
    proc_pop |-> !(fill_valid || snp_valid));
  // R9: enqueue only into a queue that had room
  p_getx_space_r9: assert property (@(posedge clk) disable iff (rst)
    getx_valid |-> $past(getx_space));
  p_xfer_space_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> $past(xfer_space));
  // R2: the issuing processor request stays queued
  p_getx_nopop_r2: assert property (@(posedge clk) disable iff (rst)
    getx_valid |-> !$past(proc_pop));
  // R3: a response follows a processor pop
  p_resp_pop_r3: assert property (@(posedge clk) disable iff (rst)
    proc_resp_valid |-> $past(proc_pop));
  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

endmodule

// File: tb/tb_mi_snoop_ctrl.sv
module tb_mi_snoop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int NW = 2;
  localparam int MYID = 1;
  localparam int NBLK = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          proc_valid = 0, proc_write = 0;
  logic [AW-1:0] proc_addr = 0;
  logic [DW-1:0] proc_wdata = 0;
  logic          snp_valid = 0;
  logic [AW-1:0] snp_addr = 0;
  logic [1:0]    snp_type = 0;
  logic [NW-1:0] snp_src = 0;
  logic          fill_valid = 0;
  logic [AW-1:0] fill_addr = 0;
  logic [DW-1:0] fill_data = 0;
  logic          getx_space = 1, xfer_space = 1;

  logic          proc_pop, snp_pop, fill_pop;
  logic          proc_resp_valid, getx_valid, xfer_valid, err_flag;
  logic [DW-1:0] proc_resp_data, xfer_data;
  logic [AW-1:0] getx_addr, xfer_addr;
  logic [1:0]    getx_type;
  logic [NW-1:0] getx_src, xfer_dest;

  mi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NODE_W(NW), .NODE_ID(MYID)) dut (
    .clk(clk), .rst(rst),
    .proc_valid(proc_valid), .proc_write(proc_write), .proc_addr(proc_addr),
    .proc_wdata(proc_wdata), .proc_pop(proc_pop),
    .proc_resp_valid(proc_resp_valid), .proc_resp_data(proc_resp_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_type(snp_type),
    .snp_src(snp_src), .snp_pop(snp_pop),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_pop(fill_pop),
    .getx_space(getx_space), .getx_valid(getx_valid), .getx_addr(getx_addr),
    .getx_type(getx_type), .getx_src(getx_src),
    .xfer_space(xfer_space), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
    .xfer_dest(xfer_dest), .xfer_data(xfer_data),
    .err_flag(err_flag)
  );

  int tests = 0;
  int fails = 0;

  // behavioural reference: 0 idle, 1 modified, 2 transient
  int            m_st  [NBLK];
  logic [DW-1:0] m_mem [NBLK];
  logic          m_err;
  logic          e_ppop, e_spop, e_fpop;
  logic          e_getx, e_xfer, e_resp;
  logic [AW-1:0] e_gaddr, e_xaddr;
  logic [NW-1:0] e_xdest;
  logic [DW-1:0] e_data;
  string         tag;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    proc_valid = 0; snp_valid = 0; fill_valid = 0;
    getx_space = 1; xfer_space = 1;
  endtask

  // one cycle: decide from inputs, compare pops, update model, compare outputs
  task automatic step();
    int a;
    int     n_st;
    logic   n_wr;
    logic [DW-1:0] n_wd;
    #1;
    e_ppop = 0; e_spop = 0; e_fpop = 0;
    e_getx = 0; e_xfer = 0; e_resp = 0;
    n_st = -1; n_wr = 0; n_wd = '0; a = 0;
    tag = "R11";
    if (fill_valid) begin
      a = int'(fill_addr);
      e_fpop = 1;
      if (m_st[a] == 2) begin
        tag = "R7"; n_st = 1; n_wr = 1; n_wd = fill_data;
      end else begin
        tag = "R8"; m_err = 1;
      end
    end else if (snp_valid) begin
      a = int'(snp_addr);
      if (snp_type != 2'b01 || snp_src == NW'(MYID)) begin
        tag = "R10"; e_spop = 1;
      end else if (m_st[a] == 2) begin
        tag = "R6";
      end else if (m_st[a] == 0) begin
        tag = "R5"; e_spop = 1;
      end else if (xfer_space) begin
        tag = "R4"; e_spop = 1; e_xfer = 1; e_xaddr = snp_addr;
        e_xdest = snp_src; e_data = m_mem[a]; n_st = 0;
      end else begin
        tag = "R9";
      end
    end else if (proc_valid) begin
      a = int'(proc_addr);
      if (m_st[a] == 2) begin
        tag = "R6";
      end else if (m_st[a] == 1) begin
        tag = "R3"; e_ppop = 1; e_resp = 1; e_data = m_mem[a];
        if (proc_write) begin n_wr = 1; n_wd = proc_wdata; end
      end else if (getx_space) begin
        tag = "R2"; e_getx = 1; e_gaddr = proc_addr; n_st = 2;
      end else begin
        tag = "R9";
      end
    end
    check(tag, "proc_pop", 64'(proc_pop), 64'(e_ppop));
    check(tag, "snp_pop", 64'(snp_pop), 64'(e_spop));
    check(tag, "fill_pop", 64'(fill_pop), 64'(e_fpop));
    @(posedge clk);
    if (n_st >= 0) m_st[a] = n_st;
    if (n_wr) m_mem[a] = n_wd;
    @(negedge clk);
    check(tag, "getx_valid", 64'(getx_valid), 64'(e_getx));
    if (e_getx) begin
      check("R2", "getx_addr", 64'(getx_addr), 64'(e_gaddr));
      check("R2", "getx_type", 64'(getx_type), 64'(2'b01));
      check("R2", "getx_src", 64'(getx_src), 64'(MYID));
    end
    check(tag, "xfer_valid", 64'(xfer_valid), 64'(e_xfer));
    if (e_xfer) begin
      check("R4", "xfer_addr", 64'(xfer_addr), 64'(e_xaddr));
      check("R4", "xfer_dest", 64'(xfer_dest), 64'(e_xdest));
      check("R4", "xfer_data", 64'(xfer_data), 64'(e_data));
    end
    check(tag, "proc_resp_valid", 64'(proc_resp_valid), 64'(e_resp));
    if (e_resp) check("R3", "proc_resp_data", 64'(proc_resp_data), 64'(e_data));
    check(tag, "err_flag", 64'(err_flag), 64'(m_err));
  endtask

  task automatic prc(int addr, logic wr, logic [DW-1:0] wd);
    idle_inputs();
    proc_valid = 1; proc_write = wr; proc_addr = AW'(addr); proc_wdata = wd;
  endtask

  task automatic snp(int addr, int typ, int srcid);
    idle_inputs();
    snp_valid = 1; snp_addr = AW'(addr); snp_type = 2'(typ); snp_src = NW'(srcid);
  endtask

  task automatic fil(int addr, logic [DW-1:0] d);
    idle_inputs();
    fill_valid = 1; fill_addr = AW'(addr); fill_data = d;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBLK; i++) begin m_st[i] = 0; m_mem[i] = 'x; end
    m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    check("R1", "getx_valid", 64'(getx_valid), 64'd0);
    check("R1", "xfer_valid", 64'(xfer_valid), 64'd0);
    check("R1", "proc_resp_valid", 64'(proc_resp_valid), 64'd0);
    check("R1", "err_flag", 64'(err_flag), 64'd0);

    // R1/R2: every block starts idle and issues an exclusive request
    for (int b = 0; b < NBLK; b++) begin prc(b, 0, '0); step(); end
    // R6: transient blocks stall processor and foreign snoops
    prc(2, 1, 32'h1); step();
    snp(2, 1, 3); step();
    // R11: data beats a pending snoop and processor request
    for (int b = 0; b < NBLK; b++) begin
      fil(b, 32'hA000_0000 + b);
      snp_valid = 1; snp_addr = AW'(b); snp_type = 2'b01; snp_src = 2'd2;
      proc_valid = 1; proc_addr = AW'(b); proc_write = 0;
      step();
    end
    // R3: load hit, store hit (old data returned), load sees store
    prc(3, 0, '0); step();
    prc(3, 1, 32'hDEAD_BEEF); step();
    prc(3, 0, '0); step();
    // R11: snoop beats processor
    snp(5, 1, 0); proc_valid = 1; proc_addr = 3'd5; step();
    // R9: no reply space stalls the snoop
    snp(3, 1, 2); xfer_space = 0; step();
    // R4: reply with the stored data, block goes idle
    snp(3, 1, 2); step();
    // R5: foreign snoop to an idle block
    snp(3, 1, 0); step();
    // R10: own echo and a non-exclusive type on a modified block
    snp(4, 1, MYID); step();
    snp(4, 2, 3); step();
    prc(4, 0, '0); step();
    // R9: no request space stalls the processor
    prc(3, 0, '0); getx_space = 0; step();
    // R8: data for idle and for modified blocks
    fil(3, 32'h5555); step();
    fil(4, 32'h6666); step();
    prc(4, 0, '0); step();
    idle_inputs(); step();

    // random mix on four blocks
    for (int n = 0; n < 3000; n++) begin
      idle_inputs();
      proc_valid = ($urandom_range(0, 1) == 1);
      proc_write = ($urandom_range(0, 1) == 1);
      proc_addr  = AW'($urandom_range(0, 3));
      proc_wdata = $urandom;
      snp_valid  = ($urandom_range(0, 3) == 0);
      snp_addr   = AW'($urandom_range(0, 3));
      snp_type   = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
      snp_src    = NW'($urandom_range(0, 3));
      fill_valid = ($urandom_range(0, 4) == 0);
      fill_addr  = AW'($urandom_range(0, 3));
      fill_data  = $urandom;
      getx_space = ($urandom_range(0, 3) != 0);
      xfer_space = ($urandom_range(0, 3) != 0);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule